// File: doc/BRIEF.md
# SPI Burst Register-Access Slave

This block sits between an SPI bus master and a byte-wide internal register file. Each SPI frame, bounded by chip select, carries one command: a three-byte header followed by a burst of data bytes. The first header byte gives the direction in its top bit and the burst size minus one in its low seven bits. The next two header bytes give a 16-bit start address, low byte first. The block decodes the header and walks the address upward by one for each data byte. It issues one write strobe per received byte, or it fetches register bytes and shifts them out on MISO.

All SPI pins are brought into the system clock domain through synchronizer chains, and edges are detected there. The SPI clock must therefore be several times slower than the system clock. The bus uses mode 0: the clock idles low, MOSI is sampled on the rising edge, MISO changes after the falling edge, and bytes go most significant bit first. The register file answers a read strobe with data on the cycle after the strobe.

Top module: `spi_burst_regslave`

## Requirements
- R1: After reset, MISO is low and neither reg_wr_en nor reg_rd_en is asserted.
- R2: In the first header byte, bit 7 set selects a write and bit 7 clear selects a read. Bits 6:0 hold the number of data bytes minus one, so 0 means one byte and 127 means 128 bytes.
- R3: The second header byte is the low address byte and the third is the high address byte. Together they form the address of the first data byte.
- R4: In a write frame, each complete data byte produces exactly one single-cycle reg_wr_en pulse carrying that byte. The first pulse uses the start address and each later pulse uses the previous address plus one.
- R5: In a read frame, the byte at the start address is fetched once the third header byte completes. It is presented on MISO, MSB first, from the first data bit onward. Each later data byte comes from the next higher address, with one reg_rd_en pulse per byte.
- R6: A frame transfers exactly count+1 data bytes. Any further SPI clocks before chip select rises cause no strobe.
- R7: If chip select rises partway through a byte, that byte is discarded and causes no write. The next frame starts decoding a fresh header.
- R8: The address counter wraps from 0xFFFF to 0x0000 within a burst, for reads and writes alike.
- R9: A read frame never asserts reg_wr_en, and a write frame never asserts reg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_cs_n | input | 1 | Active-low chip select framing one command |
| spi_miso | output | 1 | Serial data to master |
| reg_addr | output | 16 | Register address of the current access |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write, valid with reg_wr_en |
| reg_rd_en | output | 1 | Single-cycle read strobe |
| reg_rd_data | input | 8 | Register byte, valid the cycle after reg_rd_en |

## Verification
Two situations are hard to reach from the ports, and each is driven by a bit-level task rather than the byte-level one. The first is chip select rising after only some bits of a data byte. The bench clocks a full data byte and then half of the next byte before releasing chip select. It then checks that only the whole byte was written and that the following frame decodes its header from scratch. The second is the narrow window between the last header bit and the first data bit of a read, where the prefetch must land on MISO. The bench samples MISO just before each rising edge, so a late fetch shows up as a wrong first bit. Overrun clocks and address wrap are reached by sending more bytes than the count field allows and by starting bursts at 0xFFFE and 0xFFFF.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   // Frame phases of the command decoder
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_ADDR_LO,
      PH_ADDR_HI,
      PH_DATA,
      PH_DONE
   } phase_t;

   localparam int HEADER_BYTES = 3;

endpackage

// File: rtl/spi_burst_sync.sv
module spi_burst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic mosi_i,
   input  logic cs_n_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic mosi_s,
   output logic cs_act
);

   logic [STAGES-1:0] sclk_q;
   logic [STAGES-1:0] mosi_q;
   logic [STAGES-1:0] csn_q;
   logic              sclk_prev;

   // first stage captures the raw pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q[0] <= 1'b0;
         mosi_q[0] <= 1'b0;
         csn_q[0]  <= 1'b1;
      end else begin
         sclk_q[0] <= sclk_i;
         mosi_q[0] <= mosi_i;
         csn_q[0]  <= cs_n_i;
      end
   end

   // remaining stages of the synchronizer chain
   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sclk_q[s] <= 1'b0;
            mosi_q[s] <= 1'b0;
            csn_q[s]  <= 1'b1;
         end else begin
            sclk_q[s] <= sclk_q[s-1];
            mosi_q[s] <= mosi_q[s-1];
            csn_q[s]  <= csn_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_q[STAGES-1];
   end

   assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
   assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
   assign mosi_s    = mosi_q[STAGES-1];
   assign cs_act    = ~csn_q[STAGES-1];

endmodule

// File: rtl/spi_burst_shift.sv
module spi_burst_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              miso
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
      end else if (!cs_act) begin
         // chip select released: any partial byte is dropped
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= sclk_rise && (bit_cnt == LAST_BIT);
         if (sclk_rise) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
         end
         // at a byte boundary the falling edge keeps the freshly loaded MSB
         if (tx_load)
            tx_sh <= tx_byte;
         else if (sclk_fall && (bit_cnt != '0))
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   assign rx_byte = rx_sh;
   assign miso    = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
   import spi_burst_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_byte,
   output logic [LEN_W-1:0]  burst_len,
   output logic              is_wr
);

   localparam int HI_W = ADDR_W - DATA_W;

   phase_t            phase;
   logic [ADDR_W-1:0] ptr;
   logic [LEN_W-1:0]  xfer_cnt;
   logic              rd_ret;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         ptr         <= '0;
         xfer_cnt    <= '0;
         burst_len   <= '0;
         is_wr       <= 1'b0;
         reg_addr    <= '0;
         reg_wr_en   <= 1'b0;
         reg_wr_data <= '0;
         reg_rd_en   <= 1'b0;
         rd_ret      <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         rd_ret    <= reg_rd_en;
         if (!cs_act) begin
            phase <= PH_IDLE;
         end else begin
            unique case (phase)
               PH_IDLE: phase <= PH_CMD;
               PH_CMD: if (byte_done) begin
                  is_wr     <= rx_byte[DATA_W-1];
                  burst_len <= rx_byte[LEN_W-1:0];
                  phase     <= PH_ADDR_LO;
               end
               PH_ADDR_LO: if (byte_done) begin
                  ptr[DATA_W-1:0] <= rx_byte;
                  phase           <= PH_ADDR_HI;
               end
               PH_ADDR_HI: if (byte_done) begin
                  ptr[ADDR_W-1:DATA_W] <= rx_byte[HI_W-1:0];
                  xfer_cnt             <= '0;
                  phase                <= PH_DATA;
                  if (!is_wr) begin
                     // prefetch so the first data bit is already on MISO
                     reg_rd_en <= 1'b1;
                     reg_addr  <= {rx_byte[HI_W-1:0], ptr[DATA_W-1:0]};
                  end
               end
               PH_DATA: if (byte_done) begin
                  ptr <= ptr + 1'b1;
                  if (is_wr) begin
                     reg_wr_en   <= 1'b1;
                     reg_addr    <= ptr;
                     reg_wr_data <= rx_byte;
                  end
                  if (xfer_cnt == burst_len) begin
                     phase <= PH_DONE;
                  end else begin
                     xfer_cnt <= xfer_cnt + 1'b1;
                     if (!is_wr) begin
                        reg_rd_en <= 1'b1;
                        reg_addr  <= ptr + 1'b1;
                     end
                  end
               end
               PH_DONE: phase <= PH_DONE;
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign tx_load = rd_ret;
   assign tx_byte = rd_data;

endmodule

// File: rtl/spi_burst_regslave.sv
module spi_burst_regslave #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 16,
   parameter int LEN_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   input  logic              spi_cs_n,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rd_data
);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LEN_W > DATA_W - 1) begin : g_bad_len
      $error("LEN_W must leave the direction bit free");
   end
   if ((ADDR_W <= DATA_W) || (ADDR_W > 2 * DATA_W)) begin : g_bad_addr
      $error("ADDR_W must fit exactly two header address bytes");
   end

   logic              sclk_rise;
   logic              sclk_fall;
   logic              mosi_s;
   logic              cs_act;
   logic              byte_done;
   logic [DATA_W-1:0] rx_byte;
   logic              tx_load;
   logic [DATA_W-1:0] tx_byte;
   logic [LEN_W-1:0]  burst_len;
   logic              is_wr;

   spi_burst_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (spi_sclk),
      .mosi_i    (spi_mosi),
      .cs_n_i    (spi_cs_n),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .mosi_s    (mosi_s),
      .cs_act    (cs_act)
   );

   spi_burst_shift #(.DATA_W(DATA_W)) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .mosi_s    (mosi_s),
      .tx_load   (tx_load),
      .tx_byte   (tx_byte),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (spi_miso)
   );

   spi_burst_ctrl #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_act      (cs_act),
      .byte_done   (byte_done),
      .rx_byte     (rx_byte),
      .rd_data     (reg_rd_data),
      .reg_addr    (reg_addr),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_en   (reg_rd_en),
      .tx_load     (tx_load),
      .tx_byte     (tx_byte),
      .burst_len   (burst_len),
      .is_wr       (is_wr)
   );

endmodule

// File: rtl/spi_burst_regslave_chk.sv
module spi_burst_regslave_chk #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              reg_wr_en,
   input logic              reg_rd_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [LEN_W-1:0]  burst_len,
   input logic              is_wr
);

   logic              access;
   logic [LEN_W:0]    acc_cnt;
   logic [ADDR_W-1:0] last_addr;

   assign access = reg_wr_en | reg_rd_en;

   // accesses seen in the current frame and the address of the latest
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt   <= '0;
         last_addr <= '0;
      end else if (!cs_act) begin
         acc_cnt <= '0;
      end else if (access) begin
         acc_cnt   <= acc_cnt + 1'b1;
         last_addr <= reg_addr;
      end
   end

   // R9: direction decides which strobe may appear
   p_wr_only_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> is_wr);
   p_rd_only_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> !is_wr);

   // R4: write strobe lasts one cycle
   p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R7: writes only come from bytes completed inside a frame
   p_wr_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $past(cs_act));

   // R6: never more than count+1 accesses in one frame
   p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      access |-> (acc_cnt <= {1'b0, burst_len}));

   // R8: consecutive accesses step the address by one, wrapping
   p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (access && (acc_cnt != '0)) |-> (reg_addr == ADDR_W'(last_addr + 1'b1)));

endmodule

bind spi_burst_regslave spi_burst_regslave_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .reg_wr_en (reg_wr_en),
   .reg_rd_en (reg_rd_en),
   .reg_addr  (reg_addr),
   .burst_len (burst_len),
   .is_wr     (is_wr)
);

// File: tb/spi_burst_regslave_tb_top.sv
`timescale 1ns/1ps
module spi_burst_regslave_tb_top;

   localparam int HALF = 10;   // system cycles per SCLK half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        mosi = 1'b0;
   logic        cs_n = 1'b1;
   logic        miso;
   logic [15:0] reg_addr;
   logic        reg_wr_en;
   logic [7:0]  reg_wr_data;
   logic        reg_rd_en;
   logic [7:0]  reg_rd_data = 8'h00;

   int checks = 0;
   int fails  = 0;

   int          wr_cnt = 0;
   int          rd_cnt = 0;
   logic [15:0] wr_addr_log [0:63];
   logic [7:0]  wr_data_log [0:63];
   logic [15:0] rd_addr_log [0:63];

   logic [7:0] tx_buf [0:15];
   logic [7:0] rx_buf [0:15];

   always #2.5 clk = ~clk;   // 200 MHz

   spi_burst_regslave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_mosi    (mosi),
      .spi_cs_n    (cs_n),
      .spi_miso    (miso),
      .reg_addr    (reg_addr),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_en   (reg_rd_en),
      .reg_rd_data (reg_rd_data)
   );

   // register file content as a pure function of the address
   function automatic logic [7:0] reg_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   // register file model: one-cycle read latency, access log
   always @(posedge clk) begin
      if (reg_rd_en) begin
         reg_rd_data <= reg_val(reg_addr);
         rd_addr_log[rd_cnt[5:0]] <= reg_addr;
         rd_cnt <= rd_cnt + 1;
      end
      if (reg_wr_en) begin
         wr_addr_log[wr_cnt[5:0]] <= reg_addr;
         wr_data_log[wr_cnt[5:0]] <= reg_wr_data;
         wr_cnt <= wr_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b, output logic r);
      mosi = b;
      repeat (HALF) @(negedge clk);
      r = miso;            // master samples just before the rising edge
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         logic t;
         spi_bit(b[i], t);
         r[i] = t;
      end
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic run_txn(input int n);
      cs_begin();
      for (int i = 0; i < n; i++) begin
         logic [7:0] r;
         spi_byte(tx_buf[i], r);
         rx_buf[i] = r;
      end
      cs_end();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1 miso in reset", {31'd0, miso}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 miso after reset", {31'd0, miso}, 32'd0);
      chk("R1 wr_en after reset", {31'd0, reg_wr_en}, 32'd0);
      chk("R1 rd_en after reset", {31'd0, reg_rd_en}, 32'd0);
   endtask

   task automatic t_write_burst();
      int w0 = wr_cnt;
      int r0 = rd_cnt;
      tx_buf[0] = 8'h82; tx_buf[1] = 8'h20; tx_buf[2] = 8'h01;
      tx_buf[3] = 8'h11; tx_buf[4] = 8'h22; tx_buf[5] = 8'h33;
      run_txn(6);
      chk("R2 write count", wr_cnt - w0, 3);
      chk("R9 no reads in write", rd_cnt - r0, 0);
      for (int i = 0; i < 3; i++) begin
         chk("R3 R4 write addr", {16'd0, wr_addr_log[(w0 + i) % 64]}, 32'h0120 + i);
         chk("R4 write data", {24'd0, wr_data_log[(w0 + i) % 64]}, {24'd0, tx_buf[3 + i]});
      end
   endtask

   task automatic t_read_burst();
      int w0 = wr_cnt;
      int r0 = rd_cnt;
      tx_buf[0] = 8'h06; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
      for (int i = 3; i < 10; i++) tx_buf[i] = 8'h00;
      run_txn(10);
      chk("R5 read strobe count", rd_cnt - r0, 7);
      chk("R9 no writes in read", wr_cnt - w0, 0);
      for (int i = 0; i < 7; i++) begin
         chk("R5 read addr", {16'd0, rd_addr_log[(r0 + i) % 64]}, i);
         chk("R5 miso byte", {24'd0, rx_buf[3 + i]}, {24'd0, reg_val(16'(i))});
      end
   endtask

   task automatic t_overrun();
      int w0 = wr_cnt;
      int r0;
      tx_buf[0] = 8'h81; tx_buf[1] = 8'h00; tx_buf[2] = 8'h30;
      tx_buf[3] = 8'hC1; tx_buf[4] = 8'hC2; tx_buf[5] = 8'hC3; tx_buf[6] = 8'hC4;
      run_txn(7);
      chk("R6 write overrun count", wr_cnt - w0, 2);
      chk("R6 last write addr", {16'd0, wr_addr_log[(w0 + 1) % 64]}, 32'h3001);
      r0 = rd_cnt;
      tx_buf[0] = 8'h00; tx_buf[1] = 8'h40; tx_buf[2] = 8'h00;
      tx_buf[3] = 8'h00; tx_buf[4] = 8'h00; tx_buf[5] = 8'h00;
      run_txn(6);
      chk("R6 read overrun count", rd_cnt - r0, 1);
      chk("R6 single read byte", {24'd0, rx_buf[3]}, {24'd0, reg_val(16'h0040)});
   endtask

   task automatic t_abort();
      int w0 = wr_cnt;
      logic [7:0] r;
      logic t;
      cs_begin();
      spi_byte(8'h83, r);
      spi_byte(8'h00, r);
      spi_byte(8'h02, r);
      spi_byte(8'hAA, r);
      for (int i = 0; i < 4; i++) spi_bit(1'b1, t);   // half a byte
      cs_end();
      chk("R7 abort write count", wr_cnt - w0, 1);
      chk("R7 abort kept byte addr", {16'd0, wr_addr_log[w0 % 64]}, 32'h0200);
      chk("R7 abort kept byte data", {24'd0, wr_data_log[w0 % 64]}, 32'hAA);
      w0 = wr_cnt;
      tx_buf[0] = 8'h80; tx_buf[1] = 8'h00; tx_buf[2] = 8'h03; tx_buf[3] = 8'h5C;
      run_txn(4);
      chk("R7 next frame count", wr_cnt - w0, 1);
      chk("R7 next frame addr", {16'd0, wr_addr_log[w0 % 64]}, 32'h0300);
      chk("R7 next frame data", {24'd0, wr_data_log[w0 % 64]}, 32'h5C);
   endtask

   task automatic t_wrap();
      int w0 = wr_cnt;
      int r0;
      tx_buf[0] = 8'h81; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hFF;
      tx_buf[3] = 8'h01; tx_buf[4] = 8'h02;
      run_txn(5);
      chk("R8 wrap write count", wr_cnt - w0, 2);
      chk("R8 write at top", {16'd0, wr_addr_log[w0 % 64]}, 32'hFFFF);
      chk("R8 write wrapped", {16'd0, wr_addr_log[(w0 + 1) % 64]}, 32'h0000);
      r0 = rd_cnt;
      tx_buf[0] = 8'h02; tx_buf[1] = 8'hFE; tx_buf[2] = 8'hFF;
      tx_buf[3] = 8'h00; tx_buf[4] = 8'h00; tx_buf[5] = 8'h00;
      run_txn(6);
      chk("R8 wrap read count", rd_cnt - r0, 3);
      chk("R8 read byte FFFE", {24'd0, rx_buf[3]}, {24'd0, reg_val(16'hFFFE)});
      chk("R8 read byte FFFF", {24'd0, rx_buf[4]}, {24'd0, reg_val(16'hFFFF)});
      chk("R8 read byte 0000", {24'd0, rx_buf[5]}, {24'd0, reg_val(16'h0000)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_write_burst();
      t_read_burst();
      t_overrun();
      t_abort();
      t_wrap();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule